// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, from the first six bytes of a received frame, whether the frame should be kept. A frame-start pulse arms it, and the destination address then arrives one byte per `byte_valid` strobe, first byte first. Four acceptance modes are selected by bits of a receive-mode input:

- **Promiscuous:** every frame is taken.
- **Broadcast:** the all-ones address is taken only when enabled.
- **Multicast:** other group addresses are taken only when enabled and when a hash bit is set.
- **Unicast:** every other address must equal the programmed station address exactly.

The multicast hash is a CRC-32 over the six address bytes, accumulated one byte per strobe. Its top six bits select one bit of a 64-bit table. The table is held as eight byte-wide registers that the host writes and reads back through a small port.

The verdict and a group-address flag appear in the cycle after the sixth byte. They stay stable until the next frame start. Downstream logic uses them to commit or drop the frame. Frame storage and FCS checking sit elsewhere.

Top module: `addr_filter_top`

## Requirements
- R1: After reset `decision_valid`, `accept` and `group_addr` are 0 and all eight hash registers read 0.
- R2: A `frame_start` pulse clears `decision_valid`, `accept` and `group_addr` in the next cycle and restarts byte collection. The following bytes are ignored: bytes strobed before the first frame start after reset, bytes beyond the sixth, and a byte strobed in the same cycle as `frame_start`.
- R3: The cycle after the sixth byte is strobed, `decision_valid` is 1 and `accept`/`group_addr` carry the verdict. All three then hold unchanged until the next `frame_start`, even if the mode, station address or table change meanwhile.
- R4: With mode bit 4 set, every frame is accepted.
- R5: With mode bit 4 clear, a destination of six 0xFF bytes is accepted exactly when mode bit 2 is set.
- R6: With mode bit 4 clear, a non-broadcast destination whose first byte has bit 0 set is a group address. It is accepted only when mode bit 3 is set and its hash bit is 1.
- R7: The hash index is bits 31..26 of a CRC-32 computed as follows:
  - reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, no final inversion;
  - bytes taken in arrival order, each byte least significant bit first.

  The selected bit is bit (index mod 8) of hash register (index / 8).
- R8: With mode bit 4 clear, a destination whose first byte has bit 0 clear is accepted only when byte k equals `station_addr[8k+7:8k]` for all k in 0..5.
- R9: In the verdict cycle, `group_addr` equals bit 0 of the first address byte.
- R10: When `hash_wr_en` is 1, `hash_wr_data` is written into register `hash_addr` at the clock edge. `hash_rd_data` continuously shows register `hash_addr`.
- R11: The mode bits, station address and hash table are sampled in the cycle of the sixth byte. A table write in that same cycle affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at frame start |
| byte_valid | input | 1 | Address byte strobe |
| byte_data | input | 8 | Address byte |
| rx_cfg | input | 8 | Receive mode: bit 2 broadcast, bit 3 multicast, bit 4 promiscuous |
| station_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| hash_wr_en | input | 1 | Hash register write enable |
| hash_addr | input | 3 | Hash register select for write and read |
| hash_wr_data | input | 8 | Hash register write data |
| hash_rd_data | output | 8 | Selected hash register contents |
| decision_valid | output | 1 | Verdict present and held |
| accept | output | 1 | Frame accepted |
| group_addr | output | 1 | Destination is a group address |

## Verification
On every cycle, the bound checker checks four things:
- the verdict follows the sixth byte by one cycle and then holds;
- a frame start clears it;
- each mode's acceptance rule, expressed in terms of the separately computed broadcast, group, match and hash-hit signals;
- hash register readback after a write.

Whether those signals are themselves right cannot be seen by the assertions: the CRC value, the byte-by-byte address comparison, and the sampling of a table write in the sixth-byte cycle. Only the bench's directed frames show these, against its behavioural model.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
   // receive-mode bit positions (the host's mode register layout depends on them)
   localparam int CFG_BCAST_BIT   = 2;
   localparam int CFG_MCAST_BIT   = 3;
   localparam int CFG_PROMISC_BIT = 4;

   // reflected CRC-32 polynomial used for the group-address hash
   localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB8_8320;

   typedef enum logic [1:0] {
      ADDR_UNI   = 2'd0,
      ADDR_GROUP = 2'd1,
      ADDR_BCAST = 2'd2
   } addr_class_e;
endpackage

// File: rtl/addr_filter_crc.sv
module addr_filter_crc #(
   parameter int          CRC_W  = 32,
   parameter int          DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = addr_filter_pkg::CRC32_POLY_REFL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc_nxt
);
   logic [CRC_W-1:0] crc_q;

   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input logic [DATA_W-1:0] d);
      logic [CRC_W-1:0] r;
      r = c;
      for (int i = 0; i < DATA_W; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction

   always_comb crc_nxt = crc_step(crc_q, din);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '1;
      else if (clear) crc_q <= '1;
      else if (step)  crc_q <= crc_nxt;
   end
endmodule

// File: rtl/addr_filter_cmp.sv
module addr_filter_cmp #(
   parameter int ADDR_BYTES = 6,
   parameter int DATA_W     = 8,
   parameter int IDX_W      = $clog2(ADDR_BYTES + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         step,
   input  logic [IDX_W-1:0]             idx,
   input  logic [DATA_W-1:0]            din,
   input  logic [ADDR_BYTES*DATA_W-1:0] station,
   output logic                         uni_match_nxt,
   output logic                         all_ones_nxt,
   output logic                         group_nxt
);
   logic [DATA_W-1:0] st_b [ADDR_BYTES];
   logic match_q, ones_q, grp_q, first;

   for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_split
      assign st_b[k] = station[k*DATA_W +: DATA_W];
   end

   assign first         = (idx == '0);
   assign uni_match_nxt = (first ? 1'b1 : match_q) & (din == st_b[idx]);
   assign all_ones_nxt  = (first ? 1'b1 : ones_q) & (&din);
   assign group_nxt     = first ? din[0] : grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b1;
         ones_q  <= 1'b1;
         grp_q   <= 1'b0;
      end else if (clear) begin
         match_q <= 1'b1;
         ones_q  <= 1'b1;
         grp_q   <= 1'b0;
      end else if (step) begin
         match_q <= uni_match_nxt;
         ones_q  <= all_ones_nxt;
         grp_q   <= group_nxt;
      end
   end
endmodule

// File: rtl/addr_filter_hash.sv
module addr_filter_hash #(
   parameter int HASH_BITS = 6,
   parameter int DATA_W    = 8,
   parameter bit REG_READ  = 1'b0,
   parameter int NREG      = (2 ** HASH_BITS) / DATA_W,
   parameter int AW        = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        addr,
   input  logic [DATA_W-1:0]    wr_data,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [HASH_BITS-1:0] lk_idx,
   output logic                 hit
);
   localparam int BIT_W = $clog2(DATA_W);

   if ((2 ** HASH_BITS) % DATA_W != 0) begin : g_bad_geom
      $error("hash table size must be a multiple of the register width");
   end

   logic [DATA_W-1:0] tab [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          tab[r] <= '0;
         else if (wr_en && addr == AW'(r))    tab[r] <= wr_data;
      end
   end

   assign hit = tab[lk_idx[HASH_BITS-1:BIT_W]][lk_idx[BIT_W-1:0]];

   if (REG_READ) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= tab[addr];
      end
   end else begin : g_rd_comb
      assign rd_data = tab[addr];
   end
endmodule

// File: rtl/addr_filter_top.sv
module addr_filter_top #(
   parameter int ADDR_BYTES    = 6,
   parameter int DATA_W        = 8,
   parameter int CRC_W         = 32,
   parameter int HASH_BITS     = 6,
   parameter int CFG_W         = 8,
   parameter bit HASH_REG_READ = 1'b0
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        frame_start,
   input  logic                                        byte_valid,
   input  logic [DATA_W-1:0]                           byte_data,
   input  logic [CFG_W-1:0]                            rx_cfg,
   input  logic [ADDR_BYTES*DATA_W-1:0]                station_addr,
   input  logic                                        hash_wr_en,
   input  logic [$clog2((2**HASH_BITS)/DATA_W)-1:0]    hash_addr,
   input  logic [DATA_W-1:0]                           hash_wr_data,
   output logic [DATA_W-1:0]                           hash_rd_data,
   output logic                                        decision_valid,
   output logic                                        accept,
   output logic                                        group_addr
);
   import addr_filter_pkg::*;

   localparam int IDX_W = $clog2(ADDR_BYTES + 1);
   localparam int NREG  = (2 ** HASH_BITS) / DATA_W;
   localparam int AW    = $clog2(NREG);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_BYTES - 1);
   localparam logic [IDX_W-1:0] IDLE_IDX = IDX_W'(ADDR_BYTES);

   if (ADDR_BYTES < 1)          begin : g_bad_len   $error("ADDR_BYTES must be at least 1"); end
   if (HASH_BITS > CRC_W)       begin : g_bad_hash  $error("HASH_BITS exceeds CRC width"); end
   if (CFG_W <= CFG_PROMISC_BIT) begin : g_bad_cfg  $error("CFG_W too narrow for mode bits"); end
   if (NREG < 2)                begin : g_bad_nreg  $error("hash table needs at least two registers"); end

   logic [IDX_W-1:0] byte_cnt;
   logic             take, last_byte;
   logic [CRC_W-1:0] crc_nxt;
   logic             uni_match_nxt, all_ones_nxt, group_nxt, hash_hit, acc_nxt;
   addr_class_e      cls;

   assign take      = byte_valid && !frame_start && (byte_cnt < IDLE_IDX);
   assign last_byte = take && (byte_cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           byte_cnt <= IDLE_IDX;
      else if (frame_start) byte_cnt <= '0;
      else if (take)        byte_cnt <= byte_cnt + 1'b1;
   end

   addr_filter_crc #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .clear(frame_start), .step(take),
      .din(byte_data), .crc_nxt(crc_nxt)
   );

   addr_filter_cmp #(.ADDR_BYTES(ADDR_BYTES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clear(frame_start), .step(take),
      .idx(byte_cnt), .din(byte_data), .station(station_addr),
      .uni_match_nxt(uni_match_nxt), .all_ones_nxt(all_ones_nxt), .group_nxt(group_nxt)
   );

   addr_filter_hash #(.HASH_BITS(HASH_BITS), .DATA_W(DATA_W), .REG_READ(HASH_REG_READ),
                      .NREG(NREG), .AW(AW)) u_hash (
      .clk(clk), .rst_n(rst_n), .wr_en(hash_wr_en), .addr(hash_addr),
      .wr_data(hash_wr_data), .rd_data(hash_rd_data),
      .lk_idx(crc_nxt[CRC_W-1 -: HASH_BITS]), .hit(hash_hit)
   );

   always_comb begin
      if (all_ones_nxt)   cls = ADDR_BCAST;
      else if (group_nxt) cls = ADDR_GROUP;
      else                cls = ADDR_UNI;
      unique case (cls)
         ADDR_BCAST: acc_nxt = rx_cfg[CFG_BCAST_BIT];
         ADDR_GROUP: acc_nxt = rx_cfg[CFG_MCAST_BIT] && hash_hit;
         default:    acc_nxt = uni_match_nxt;
      endcase
      if (rx_cfg[CFG_PROMISC_BIT]) acc_nxt = 1'b1;
   end

   logic unused_cfg;
   assign unused_cfg = ^rx_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         decision_valid <= 1'b0;
         accept         <= 1'b0;
         group_addr     <= 1'b0;
      end else if (frame_start) begin
         decision_valid <= 1'b0;
         accept         <= 1'b0;
         group_addr     <= 1'b0;
      end else if (last_byte) begin
         decision_valid <= 1'b1;
         accept         <= acc_nxt;
         group_addr     <= group_nxt;
      end
   end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
   parameter int  DATA_W   = 8,
   parameter int  AW       = 3,
   parameter bit  REG_READ = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              last_byte,
   input logic              cfg_bcast,
   input logic              cfg_mcast,
   input logic              cfg_promisc,
   input logic              all_ones_nxt,
   input logic              group_nxt,
   input logic              uni_match_nxt,
   input logic              hash_hit,
   input logic              decision_valid,
   input logic              accept,
   input logic              group_addr,
   input logic              hash_wr_en,
   input logic [AW-1:0]     hash_addr,
   input logic [DATA_W-1:0] hash_wr_data,
   input logic [DATA_W-1:0] hash_rd_data
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !decision_valid |-> (!accept && !group_addr));

   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (!decision_valid && !accept && !group_addr));

   a_r3_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> decision_valid);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (decision_valid && !frame_start) |=>
         (decision_valid && $stable(accept) && $stable(group_addr)));

   a_r4_promisc: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && cfg_promisc) |=> accept);

   a_r5_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !cfg_promisc && all_ones_nxt) |=> (accept == $past(cfg_bcast)));

   a_r6_mcast: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !cfg_promisc && !all_ones_nxt && group_nxt) |=>
         (accept == $past(cfg_mcast && hash_hit)));

   a_r8_unicast: assert property (@(posedge clk) disable iff (!rst_n)
      (last_byte && !cfg_promisc && !group_nxt) |=> (accept == $past(uni_match_nxt)));

   a_r9_group_flag: assert property (@(posedge clk) disable iff (!rst_n)
      last_byte |=> (group_addr == $past(group_nxt)));

   if (!REG_READ) begin : g_rb
      a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
         hash_wr_en |=> ((hash_addr != $past(hash_addr)) ||
                         (hash_rd_data == $past(hash_wr_data))));
   end
endmodule

bind addr_filter_top addr_filter_chk #(
   .DATA_W(DATA_W), .AW(AW), .REG_READ(HASH_REG_READ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .last_byte(last_byte),
   .cfg_bcast(rx_cfg[addr_filter_pkg::CFG_BCAST_BIT]),
   .cfg_mcast(rx_cfg[addr_filter_pkg::CFG_MCAST_BIT]),
   .cfg_promisc(rx_cfg[addr_filter_pkg::CFG_PROMISC_BIT]),
   .all_ones_nxt(all_ones_nxt), .group_nxt(group_nxt), .uni_match_nxt(uni_match_nxt),
   .hash_hit(hash_hit), .decision_valid(decision_valid), .accept(accept),
   .group_addr(group_addr), .hash_wr_en(hash_wr_en), .hash_addr(hash_addr),
   .hash_wr_data(hash_wr_data), .hash_rd_data(hash_rd_data)
);

// File: tb/addr_filter_top_tb.sv
module addr_filter_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0, byte_valid = 1'b0, hash_wr_en = 1'b0;
   logic [7:0]  byte_data = '0, rx_cfg = '0, hash_wr_data = '0;
   logic [47:0] station_addr = '0;
   logic [2:0]  hash_addr = '0;
   logic [7:0]  hash_rd_data;
   logic        decision_valid, accept, group_addr;

   int    checks = 0, errors = 0, cyc = 0;
   bit    run_cmp = 1'b0;
   string cur_tag = "R1";

   always #2 clk = ~clk;

   addr_filter_top u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
      .byte_data(byte_data), .rx_cfg(rx_cfg), .station_addr(station_addr),
      .hash_wr_en(hash_wr_en), .hash_addr(hash_addr), .hash_wr_data(hash_wr_data),
      .hash_rd_data(hash_rd_data), .decision_valid(decision_valid), .accept(accept),
      .group_addr(group_addr)
   );

   // ---------------- reference model ----------------
   int         m_cnt = 6;
   logic [7:0] m_q[$];
   logic       m_valid = 1'b0, m_acc = 1'b0, m_grp = 1'b0;
   logic [7:0] m_tab [8];

   function automatic logic [31:0] crc_of(input logic [47:0] d);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int k = 0; k < 48; k++) begin
         if (c[0] ^ d[k]) c = (c >> 1) ^ 32'hEDB8_8320;
         else             c = c >> 1;
      end
      return c;
   endfunction

   function automatic logic model_decide();
      logic [47:0] d;
      logic [5:0]  ix;
      for (int k = 0; k < 6; k++) d[8*k +: 8] = m_q[k];
      ix = crc_of(d) >> 26;
      if (rx_cfg[4])            return 1'b1;
      if (d == '1)              return rx_cfg[2];
      if (d[0])                 return rx_cfg[3] && m_tab[ix / 8][ix % 8];
      return d == station_addr;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 6; m_q.delete(); m_valid = 0; m_acc = 0; m_grp = 0;
         for (int r = 0; r < 8; r++) m_tab[r] = '0;
      end else begin
         if (frame_start) begin
            m_cnt = 0; m_q.delete(); m_valid = 0; m_acc = 0; m_grp = 0;
         end else if (byte_valid && m_cnt < 6) begin
            m_q.push_back(byte_data);
            m_cnt++;
            if (m_cnt == 6) begin
               m_acc = model_decide(); m_grp = m_q[0][0]; m_valid = 1'b1;
            end
         end
         if (hash_wr_en) m_tab[hash_addr] = hash_wr_data;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && run_cmp) begin
         chk(cur_tag, "decision_valid", 32'(decision_valid), 32'(m_valid));
         chk(cur_tag, "accept", 32'(accept), 32'(m_acc));
         chk("R9", "group_addr", 32'(group_addr), 32'(m_grp));
         chk("R10", "hash_rd_data", 32'(hash_rd_data), 32'(m_tab[hash_addr]));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic send(input logic [47:0] d, input int nb, input bit lw,
                       input logic [2:0] la, input logic [7:0] ldat);
      tick(); frame_start = 1'b1; byte_valid = 1'b0;
      tick(); frame_start = 1'b0;
      for (int k = 0; k < nb; k++) begin
         byte_valid = 1'b1;
         byte_data  = (k < 6) ? d[8*k +: 8] : 8'hA5;
         hash_wr_en = lw && (k == 5);
         hash_addr  = la; hash_wr_data = ldat;
         tick();
      end
      byte_valid = 1'b0; hash_wr_en = 1'b0;
      repeat (3) tick();
   endtask

   task automatic wr_hash(input logic [2:0] a, input logic [7:0] v);
      hash_wr_en = 1'b1; hash_addr = a; hash_wr_data = v;
      tick();
      hash_wr_en = 1'b0;
   endtask

   function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
      return {b5, b4, b3, b2, b1, b0};
   endfunction

   initial begin
      logic [47:0] mc, mc2;
      logic [5:0]  ix;
      station_addr = mk(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56);
      repeat (3) tick();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "valid after reset", 32'(decision_valid), 0);
      chk("R1", "accept after reset", 32'(accept), 0);
      chk("R1", "group after reset", 32'(group_addr), 0);
      run_cmp = 1'b1;
      for (int r = 0; r < 8; r++) begin hash_addr = 3'(r); tick(); end

      // R2: bytes before any frame start are ignored
      cur_tag = "R2";
      for (int k = 0; k < 8; k++) begin byte_valid = 1'b1; byte_data = station_addr[8*(k%6) +: 8]; tick(); end
      byte_valid = 1'b0; tick();
      chk("R2", "no verdict without start", 32'(decision_valid), 0);

      // R8: unicast exact match and mismatches
      cur_tag = "R8";
      send(station_addr, 6, 0, 0, 0);
      chk("R8", "unicast match", 32'(accept), 1);
      send(station_addr ^ 48'h01_0000_0000_00, 6, 0, 0, 0);
      send(station_addr ^ 48'h00_0000_0000_02, 6, 0, 0, 0);

      // R3: verdict holds while mode and station change
      cur_tag = "R3";
      send(station_addr, 6, 0, 0, 0);
      rx_cfg = 8'h1C; station_addr = '0; repeat (4) tick();
      chk("R3", "held accept", 32'(accept), 1);
      station_addr = mk(8'h52, 8'h54, 8'h00, 8'h12, 8'h34, 8'h56); rx_cfg = 8'h00;

      // R2: bytes beyond the sixth, and a byte in the start cycle
      cur_tag = "R2";
      send(station_addr, 9, 0, 0, 0);
      chk("R2", "extra bytes ignored", 32'(accept), 1);
      tick(); frame_start = 1'b1; byte_valid = 1'b1; byte_data = 8'hEE;
      tick(); frame_start = 1'b0;
      for (int k = 0; k < 6; k++) begin byte_data = station_addr[8*k +: 8]; tick(); end
      byte_valid = 1'b0; repeat (2) tick();
      chk("R2", "start-cycle byte dropped", 32'(accept), 1);

      // R5: broadcast gating
      cur_tag = "R5";
      send('1, 6, 0, 0, 0);
      chk("R5", "bcast blocked", 32'(accept), 0);
      rx_cfg = 8'h04; send('1, 6, 0, 0, 0);
      chk("R5", "bcast allowed", 32'(accept), 1);
      rx_cfg = 8'h08; send('1, 6, 0, 0, 0);

      // R4: promiscuous
      cur_tag = "R4";
      rx_cfg = 8'h10;
      send(mk(8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00, 8'h01), 6, 0, 0, 0);
      chk("R4", "promisc unicast", 32'(accept), 1);
      send('1, 6, 0, 0, 0);
      send(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 6, 0, 0, 0);

      // R10: hash register write and read back
      cur_tag = "R10";
      rx_cfg = 8'h00;
      for (int r = 0; r < 8; r++) wr_hash(3'(r), 8'(8'h11 * (r + 1)));
      for (int r = 7; r >= 0; r--) begin hash_addr = 3'(r); tick(); end
      for (int r = 0; r < 8; r++) wr_hash(3'(r), 8'h00);

      // R7/R6: multicast hash selection
      mc = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'hFB);
      ix = crc_of(mc) >> 26;
      cur_tag = "R7";
      wr_hash(3'(ix / 8), 8'(1 << (ix % 8)));
      rx_cfg = 8'h08; send(mc, 6, 0, 0, 0);
      chk("R7", "hash bit hit", 32'(accept), 1);
      cur_tag = "R6";
      rx_cfg = 8'h00; send(mc, 6, 0, 0, 0);
      chk("R6", "mcast disabled", 32'(accept), 0);
      rx_cfg = 8'h04; send(mc, 6, 0, 0, 0);
      cur_tag = "R7";
      for (int r = 0; r < 8; r++) wr_hash(3'(r), 8'hFF);
      wr_hash(3'(ix / 8), ~8'(1 << (ix % 8)));
      rx_cfg = 8'h08; send(mc, 6, 0, 0, 0);
      chk("R7", "only other bits set", 32'(accept), 0);
      mc2 = mk(8'h33, 8'h33, 8'hFF, 8'h12, 8'h34, 8'h56);
      send(mc2, 6, 0, 0, 0);

      // R11: table write in the sixth-byte cycle affects only later frames
      cur_tag = "R11";
      for (int r = 0; r < 8; r++) wr_hash(3'(r), 8'h00);
      wr_hash(3'(ix / 8), 8'(1 << (ix % 8)));
      send(mc, 6, 1, 3'(ix / 8), 8'h00);
      chk("R11", "old table used", 32'(accept), 1);
      send(mc, 6, 0, 0, 0);
      chk("R11", "new table used", 32'(accept), 0);

      repeat (4) tick();
      run_cmp = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule